// File: doc/BRIEF.md
# Five-Decade BCD Counter with Nines Carries

This block is a static up-counter that holds its count as four binary-coded decimal digits and one extra overload digit, for a range of 0 to 19999. Every rising edge of the count clock adds one to the count. Two level-sensitive controls act at once, without waiting for a count edge. A clear input forces the count to zero. A preset input forces the count to full scale. Clear wins over preset, and once clear drops while preset is still high, the count moves to full scale.

The block drives active-low carry flags for decades two, three and four, plus an overload flag. Logic downstream can use these flags to cascade further counters or to build time bases. All five digit values go straight out to a latch stage that captures them. The carry flags for decades two to four stay high while preset is held. They reflect the nines pattern only after preset is released. The interface carries no stream of data, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `five_decade_counter`

## Requirements
- R1: Each digit field `digits_o[4*i+3:4*i]` holds decade i+1 in BCD, with decade one the least significant. Every field stays within 0 to 9. The count value is 10000 times `ovf_digit_o` plus the decimal value of the four digits.
- R2: While `clr_i` and `pre_i` are both low, each rising edge of `cnt_clk_i` raises the count by exactly one.
- R3: A high on `clr_i` forces the count to 00000 without a count edge. The clear overrides `pre_i` and count edges for as long as it is held.
- R4: A high on `pre_i` with `clr_i` low forces the count to 19999 without a count edge. Count edges while it is held leave the count unchanged. If `clr_i` falls while `pre_i` is high, the count goes to 19999.
- R5: With `pre_i` low, `carry_n_o[k-2]` (k = 2, 3, 4) is low exactly when the lowest k decades all hold 9. Otherwise it is high.
- R6: `ovf_carry_n_o` is low exactly when the overload digit is 1, i.e. from 10000 up. This holds during preset as well.
- R7: While `pre_i` is high, all bits of `carry_n_o` are high even though the count reads 19999. They fall as soon as `pre_i` is released.
- R8: A count edge at 19999 wraps the count to 00000, clears the overload digit and returns every carry flag high.
- R9: A decade advances only when all lower decades hold 9, and each decade rolls from 9 to 0. So 99 steps to 100, 999 to 1000, and 9999 to 10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cnt_clk_i | input | 1 | Count clock; the count advances on its rising edge |
| clr_i | input | 1 | Asynchronous clear to zero, active high, dominant |
| pre_i | input | 1 | Asynchronous preset to 19999, active high |
| digits_o | output | 4*NUM_DEC (16) | Decade digits in BCD, decade one in bits 3:0 |
| ovf_digit_o | output | 1 | Overload digit (ten-thousands bit) |
| carry_n_o | output | NUM_DEC-1 (3) | Active-low nines carries, bit 0 for decade two |
| ovf_carry_n_o | output | 1 | Active-low overload flag |

## Verification
The state that is hardest to reach from the ports is the overload boundary. Getting from 09999 to 10000, and from there to the 19999 wrap, takes thousands of count edges. The stimulus table therefore includes long runs of count edges that sweep the counter through every decade rollover and into the overload range. Other orderings matter only in short windows: preset held across count edges, clear released while preset is still high, and the carry flags sampled just before and after preset falls. Directed sequences after the table cover these by moving the controls between count edges.

// File: rtl/five_decade_counter_pkg.sv
package five_decade_counter_pkg;

  localparam int unsigned DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] bcd_t;

  localparam bcd_t BCD_ZERO = 4'd0;
  localparam bcd_t BCD_NINE = 4'd9;

  // Next value of one decade when it is told to advance: 9 rolls to 0.
  function automatic bcd_t bcd_step(input bcd_t cur);
    bcd_t nxt;
    if (cur >= BCD_NINE) nxt = BCD_ZERO;
    else                 nxt = cur + 4'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/bcd_decade.sv
module bcd_decade
  import five_decade_counter_pkg::*;
(
  input  logic cnt_clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic adv_i,
  output bcd_t digit_o,
  output logic nine_o
);

  bcd_t digit_q;

  // Clear dominates; set loads full scale; otherwise advance on request.
  always_ff @(posedge cnt_clk_i or posedge rst_i or posedge set_i) begin
    if (rst_i)      digit_q <= BCD_ZERO;
    else if (set_i) digit_q <= BCD_NINE;
    else if (adv_i) digit_q <= bcd_step(digit_q);
  end

  assign digit_o = digit_q;
  assign nine_o  = (digit_q == BCD_NINE);

endmodule

// File: rtl/overload_bit.sv
module overload_bit (
  input  logic cnt_clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic adv_i,
  output logic ovf_o
);

  logic ovf_q;

  // Single-bit top stage: toggles on a full nines carry, so 19999 wraps to 0.
  always_ff @(posedge cnt_clk_i or posedge rst_i or posedge set_i) begin
    if (rst_i)      ovf_q <= 1'b0;
    else if (set_i) ovf_q <= 1'b1;
    else if (adv_i) ovf_q <= ~ovf_q;
  end

  assign ovf_o = ovf_q;

endmodule

// File: rtl/nines_carry_decode.sv
module nines_carry_decode #(
  parameter int unsigned NUM_DEC = 4
) (
  input  logic [NUM_DEC:0]   low_nines_i,
  input  logic               pre_i,
  input  logic               ovf_i,
  output logic [NUM_DEC-2:0] carry_n_o,
  output logic               ovf_carry_n_o
);

  // low_nines_i[k] is high when decades 1..k all hold 9.
  for (genvar k = 2; k <= NUM_DEC; k++) begin : g_carry
    assign carry_n_o[k-2] = ~(low_nines_i[k] & ~pre_i);
  end

  // Overload flag follows the overload digit and is not masked by preset.
  assign ovf_carry_n_o = ~ovf_i;

endmodule

// File: rtl/five_decade_counter.sv
module five_decade_counter
  import five_decade_counter_pkg::*;
#(
  parameter int unsigned NUM_DEC = 4
) (
  input  logic                       cnt_clk_i,
  input  logic                       clr_i,
  input  logic                       pre_i,
  output logic [NUM_DEC*DIGIT_W-1:0] digits_o,
  output logic                       ovf_digit_o,
  output logic [NUM_DEC-2:0]         carry_n_o,
  output logic                       ovf_carry_n_o
);

  localparam int unsigned CHAIN_W = NUM_DEC + 1;

  // Effective preset: rises again when clear is released under a held preset.
  logic               set_w;
  logic [CHAIN_W-1:0] adv_w;
  logic [NUM_DEC-1:0] nine_w;
  logic               ovf_w;

  assign set_w    = pre_i & ~clr_i;
  assign adv_w[0] = 1'b1;

  for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
    bcd_t digit_w;

    bcd_decade u_dec (
      .cnt_clk_i (cnt_clk_i),
      .rst_i     (clr_i),
      .set_i     (set_w),
      .adv_i     (adv_w[i]),
      .digit_o   (digit_w),
      .nine_o    (nine_w[i])
    );

    assign digits_o[i*DIGIT_W +: DIGIT_W] = digit_w;
    assign adv_w[i+1] = adv_w[i] & nine_w[i];
  end

  overload_bit u_ovf (
    .cnt_clk_i (cnt_clk_i),
    .rst_i     (clr_i),
    .set_i     (set_w),
    .adv_i     (adv_w[NUM_DEC]),
    .ovf_o     (ovf_w)
  );

  assign ovf_digit_o = ovf_w;

  nines_carry_decode #(.NUM_DEC(NUM_DEC)) u_carry (
    .low_nines_i   (adv_w),
    .pre_i         (pre_i),
    .ovf_i         (ovf_w),
    .carry_n_o     (carry_n_o),
    .ovf_carry_n_o (ovf_carry_n_o)
  );

endmodule

// File: rtl/five_decade_counter_chk.sv
module five_decade_counter_chk #(
  parameter int unsigned NUM_DEC = 4
) (
  input logic                 cnt_clk_i,
  input logic                 clr_i,
  input logic                 pre_i,
  input logic [NUM_DEC*4-1:0] digits_o,
  input logic                 ovf_digit_o,
  input logic [NUM_DEC-2:0]   carry_n_o,
  input logic                 ovf_carry_n_o
);

  localparam logic [31:0] MODULUS   = 32'(2 * (10 ** NUM_DEC));
  localparam logic [31:0] FULL_SCAL = MODULUS - 32'd1;

  logic [31:0]      val_w;
  logic             bad_digit_w;
  logic [NUM_DEC:0] lownine_w;
  logic             clean_q;

  always_comb begin
    val_w       = {31'd0, ovf_digit_o};
    bad_digit_w = 1'b0;
    for (int i = NUM_DEC - 1; i >= 0; i--) begin
      val_w = val_w * 32'd10 + {28'd0, digits_o[i*4 +: 4]};
    end
    for (int i = 0; i < NUM_DEC; i++) begin
      if (digits_o[i*4 +: 4] > 4'd9) bad_digit_w = 1'b1;
    end
    lownine_w[0] = 1'b1;
    for (int i = 0; i < NUM_DEC; i++) begin
      lownine_w[i+1] = lownine_w[i] && (digits_o[i*4 +: 4] == 4'd9);
    end
  end

  // Set after a count edge with both controls low; cleared by either control.
  always_ff @(posedge cnt_clk_i or posedge clr_i or posedge pre_i) begin
    if (clr_i || pre_i) clean_q <= 1'b0;
    else                clean_q <= 1'b1;
  end

  a_r1_digit_range: assert property (@(posedge cnt_clk_i) disable iff (clr_i)
    !bad_digit_w);

  a_r2_increment: assert property (@(posedge cnt_clk_i) disable iff (clr_i || pre_i)
    clean_q |-> val_w == ($past(val_w) + 32'd1) % MODULUS);

  a_r3_clear_zero: assert property (@(posedge cnt_clk_i)
    clr_i |-> (val_w == 32'd0) && ovf_carry_n_o && (&carry_n_o));

  a_r4_preset_full: assert property (@(posedge cnt_clk_i) disable iff (clr_i)
    pre_i |-> (val_w == FULL_SCAL) && ovf_digit_o);

  a_r6_ovf_flag: assert property (@(posedge cnt_clk_i) disable iff (clr_i)
    ovf_carry_n_o == !(val_w >= (MODULUS >> 1)));

  a_r7_preset_mask: assert property (@(posedge cnt_clk_i) disable iff (clr_i)
    pre_i |-> (&carry_n_o));

  for (genvar k = 2; k <= NUM_DEC; k++) begin : g_r5
    a_r5_carry_nines: assert property (@(posedge cnt_clk_i) disable iff (clr_i || pre_i)
      carry_n_o[k-2] == !lownine_w[k]);
  end

endmodule

bind five_decade_counter five_decade_counter_chk #(.NUM_DEC(NUM_DEC)) u_chk (
  .cnt_clk_i     (cnt_clk_i),
  .clr_i         (clr_i),
  .pre_i         (pre_i),
  .digits_o      (digits_o),
  .ovf_digit_o   (ovf_digit_o),
  .carry_n_o     (carry_n_o),
  .ovf_carry_n_o (ovf_carry_n_o)
);

// File: tb/five_decade_counter_bench.sv
module five_decade_counter_bench;

  logic        cnt_clk;
  logic        clr;
  logic        pre;
  logic [15:0] digits;
  logic        ovf_digit;
  logic [2:0]  carry_n;
  logic        ovf_carry_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  five_decade_counter u_five_decade_counter (
    .cnt_clk_i     (cnt_clk),
    .clr_i         (clr),
    .pre_i         (pre),
    .digits_o      (digits),
    .ovf_digit_o   (ovf_digit),
    .carry_n_o     (carry_n),
    .ovf_carry_n_o (ovf_carry_n)
  );

  // Row layout: {op[1:0], edge count[15:0], expected value[14:0]}
  localparam logic [1:0] OP_CLR = 2'd0, OP_PRE = 2'd1, OP_CNT = 2'd2;
  localparam int NROWS = 16;
  localparam logic [32:0] TBL [NROWS] = '{
    {OP_CLR, 16'd0,    15'd0},
    {OP_CNT, 16'd1,    15'd1},
    {OP_CNT, 16'd8,    15'd9},
    {OP_CNT, 16'd1,    15'd10},
    {OP_CNT, 16'd89,   15'd99},
    {OP_CNT, 16'd1,    15'd100},
    {OP_CNT, 16'd899,  15'd999},
    {OP_CNT, 16'd1,    15'd1000},
    {OP_CLR, 16'd0,    15'd0},
    {OP_PRE, 16'd0,    15'd19999},
    {OP_CNT, 16'd1,    15'd0},
    {OP_CNT, 16'd9999, 15'd9999},
    {OP_CNT, 16'd1,    15'd10000},
    {OP_CNT, 16'd9998, 15'd19998},
    {OP_CNT, 16'd1,    15'd19999},
    {OP_CNT, 16'd1,    15'd0}
  };

  // 100 MHz count clock, generated only when edges are requested.
  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      #5 cnt_clk = 1'b1;
      #5 cnt_clk = 1'b0;
    end
  endtask

  function automatic int port_value();
    int v = int'(ovf_digit);
    for (int i = 3; i >= 0; i--) v = v * 10 + int'(digits[i*4 +: 4]);
    return v;
  endfunction

  task automatic expect_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Full port check against the expected count, derived from the requirements.
  task automatic check_state(input string tag, input int exp);
    int mod;
    int digit_ok = 1;
    logic [2:0] exp_carry;
    for (int i = 0; i < 4; i++) if (digits[i*4 +: 4] > 4'd9) digit_ok = 0;
    expect_eq("R1", "digit range", digit_ok, 1);
    expect_eq(tag, "count", port_value(), exp);
    mod = 10;
    for (int k = 2; k <= 4; k++) begin
      mod = mod * 10;
      exp_carry[k-2] = !(((exp % mod) == mod - 1) && !pre);
    end
    expect_eq(pre ? "R7" : "R5", "carry_n", int'(carry_n), int'(exp_carry));
    expect_eq("R6", "ovf_carry_n", int'(ovf_carry_n), (exp >= 10000) ? 0 : 1);
  endtask

  initial begin
    cnt_clk = 1'b0;
    clr     = 1'b1;
    pre     = 1'b0;
    #3;
    check_state("R3", 0);
    #4 clr = 1'b0;
    #3;

    // Table walk.
    for (int r = 0; r < NROWS; r++) begin
      logic [1:0]  op;
      logic [15:0] n;
      int          exp;
      string       tag;
      op  = TBL[r][32:31];
      n   = TBL[r][30:15];
      exp = int'(TBL[r][14:0]);
      case (op)
        OP_CLR: begin clr = 1'b1; #2 clr = 1'b0; tag = "R3"; end
        OP_PRE: begin pre = 1'b1; #2 pre = 1'b0; tag = "R4"; end
        default: begin
          pulses(int'(n));
          tag = (exp == 0) ? "R8" : "R9";
        end
      endcase
      #2;
      check_state(tag, exp);
    end

    // R2: single steps from a mid value.
    clr = 1'b1; #2 clr = 1'b0;
    pulses(122);
    #1 check_state("R2", 122);
    pulses(1);
    #1 check_state("R2", 123);

    // R4: preset from arbitrary value, no edge; count edges ignored while held.
    pre = 1'b1;
    #1 check_state("R4", 19999);
    expect_eq("R7", "carry_n under preset", int'(carry_n), 7);
    expect_eq("R6", "ovf flag under preset", int'(ovf_carry_n), 0);
    pulses(3);
    #1 check_state("R4", 19999);
    // R7: release preset, carries fall without an edge.
    pre = 1'b0;
    #1 expect_eq("R7", "carry_n after release", int'(carry_n), 0);
    check_state("R5", 19999);
    pulses(1);
    #1 check_state("R8", 0);

    // R3: clear dominates preset, and edges do nothing while clear is held.
    pulses(45);
    pre = 1'b1; #1 clr = 1'b1;
    #1 check_state("R3", 0);
    pulses(2);
    #1 check_state("R3", 0);
    // R4: clear falls while preset is held, count goes to full scale.
    clr = 1'b0;
    #1 check_state("R4", 19999);
    pre = 1'b0;
    #1;

    // R3: asynchronous clear mid-count, no edge involved.
    pulses(3);
    #1 clr = 1'b1;
    #1 check_state("R3", 0);
    clr = 1'b0;
    #1;
    pulses(1);
    #1 check_state("R2", 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule